// File: doc/BRIEF.md
# Search Triplet Engine

This block carries out one branch step of a 1-Wire ROM search as a single hardware operation. On a start strobe it issues three single-bit slots to a bus-level slot master: a read of the ID bit, a read of the complement bit, and then a write of the branch direction it has chosen. It then reports a packed 3-bit code with a one-cycle done strobe. The surrounding search loop uses the code to track discrepancies. The engine itself keeps no state from one step to the next.

The slot master is told to run a slot by a one-cycle `slotGo` pulse, with `slotWrite` giving the slot type and `slotWrBit` giving the bit for a write. The master answers with a one-cycle `slotAck`, and for a read it presents the sampled line on `slotRxBit` in that same cycle. If the master does not answer within `TIMEOUT_CYC` cycles, the step is abandoned and reported as "no device".

Top module: `srch_triplet`

## Requirements
- R1: With the engine idle, a high `startReq` at a clock edge starts a step. `busy` rises and `slotGo` pulses for one cycle in the next cycle with `slotWrite`=0, which is the ID-bit read.
- R2: The slots run in a fixed order: ID read, then complement read, then direction write (`slotWrite`=1). Each `slotGo` comes in the cycle after the edge that accepted the previous slot's `slotAck`. A `slotAck` seen while no slot is outstanding is ignored.
- R3: If both read bits are 1, the result is 3 (binary 011) and no write slot is issued.
- R4: If both read bits are 0, the direction is the `dirReq` value sampled with the accepted `startReq`. The write carries that bit, and the result is 4 for direction 1 or 0 for direction 0.
- R5: If exactly one read bit is 1, the direction is forced to the ID bit and written. The result is 5 when the ID bit is 1 and 2 when it is 0.
- R6: The result code is packed as bit 0 = ID bit, bit 1 = complement bit, bit 2 = direction taken. The only codes ever reported are 0, 2, 3, 4 and 5.
- R7: If `slotAck` is absent for all `TIMEOUT_CYC` cycles after a `slotGo` cycle, the step aborts with result 3 and issues no further slot. An acknowledge in the last of those cycles is still accepted.
- R8: While `busy` is high, `startReq` and `dirReq` have no effect: no extra slot, no extra done, and no change of direction.
- R9: `done` is high for exactly one cycle, in the cycle after the edge that finishes the step, and `busy` is low in that cycle. `resultCode` changes only at that edge and holds until the next completion. A start in the done cycle is accepted.
- R10: After reset, `busy`, `slotGo`, `slotWrite` and `done` are 0 and `resultCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start one search step (sampled while idle) |
| dirReq | input | 1 | Requested branch direction for the conflict case |
| slotGo | output | 1 | One-cycle request for the slot master to run a slot |
| slotWrite | output | 1 | Slot type: 1 = write, 0 = read |
| slotWrBit | output | 1 | Bit to drive in a write slot |
| slotAck | input | 1 | One-cycle slot completion from the slot master |
| slotRxBit | input | 1 | Sampled bus bit, valid with `slotAck` on a read |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle completion strobe |
| resultCode | output | 3 | {direction, complement bit, ID bit}, or 3 for no device or abort |

## Verification
`slotGo` is due one cycle after the accepting start edge, and again one cycle after each accepted acknowledge. `done` and the new `resultCode` appear one cycle after the final acknowledge edge. On an abort they appear in the cycle that follows the last of the `TIMEOUT_CYC` waiting cycles. The bench keeps a behavioural model that advances on each rising edge from the same sampled inputs. It compares every output with that model at each falling edge, so a response that is one cycle early or late shows up as a mismatch in that cycle. Per-step checks of the code, the number of written slots and the written bit are taken in the cycle where `done` is seen.

// File: rtl/srch_pkg.sv
package srch_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ID   = 2'd1,
    PH_CMP  = 2'd2,
    PH_WR   = 2'd3
  } phase_e;

  // strobes from the sequencer to the bit datapath
  typedef struct packed {
    logic accept;    // start accepted: latch requested direction
    logic capId;     // ID read acknowledged
    logic capCmp;    // complement read acknowledged
    logic finishOk;  // write acknowledged: publish packed code
    logic giveUp;    // no device or slot timeout: publish code 3
  } dpStrobe_t;

  localparam logic [2:0] CODE_NONE = 3'b011;

endpackage

// File: rtl/srch_ctrl.sv
module srch_ctrl
  import srch_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      slotAck,
  input  logic      bothOnes,
  output dpStrobe_t stb,
  output logic      slotGo,
  output logic      slotWrite,
  output logic      busy
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(TIMEOUT_CYC - 1);

  phase_e           phase, phaseNext;
  logic             issued, issuedNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             ackSeen, expire;

  assign ackSeen = issued & slotAck;
  assign expire  = issued & ~slotAck & (waitCnt == LAST_WAIT);

  assign busy      = (phase != PH_IDLE);
  assign slotGo    = busy & ~issued;
  assign slotWrite = (phase == PH_WR);

  always_comb begin
    stb          = '0;
    stb.accept   = (phase == PH_IDLE) & startReq;
    stb.capId    = ackSeen & (phase == PH_ID);
    stb.capCmp   = ackSeen & (phase == PH_CMP);
    stb.finishOk = ackSeen & (phase == PH_WR);
    stb.giveUp   = expire | (ackSeen & (phase == PH_CMP) & bothOnes);
  end

  always_comb begin
    phaseNext   = phase;
    issuedNext  = issued;
    waitCntNext = waitCnt;
    if (phase == PH_IDLE) begin
      if (startReq) begin
        phaseNext  = PH_ID;
        issuedNext = 1'b0;
      end
    end else if (!issued) begin
      issuedNext  = 1'b1;
      waitCntNext = '0;
    end else if (slotAck) begin
      issuedNext = 1'b0;
      unique case (phase)
        PH_ID:   phaseNext = PH_CMP;
        PH_CMP:  phaseNext = bothOnes ? PH_IDLE : PH_WR;
        PH_WR:   phaseNext = PH_IDLE;
        default: phaseNext = PH_IDLE;
      endcase
    end else if (expire) begin
      phaseNext  = PH_IDLE;
      issuedNext = 1'b0;
    end else begin
      waitCntNext = waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      issued  <= 1'b0;
      waitCnt <= '0;
    end else begin
      phase   <= phaseNext;
      issued  <= issuedNext;
      waitCnt <= waitCntNext;
    end
  end

endmodule

// File: rtl/srch_dp.sv
module srch_dp
  import srch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirReq,
  input  logic       slotRxBit,
  input  dpStrobe_t  stb,
  output logic       bothOnes,
  output logic       slotWrBit,
  output logic [2:0] resultCode,
  output logic       done
);

  logic idBit, cmpBit, dirBit;

  // the complement bit arrives now; the ID bit was captured earlier
  assign bothOnes  = idBit & slotRxBit;
  assign slotWrBit = dirBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idBit  <= 1'b0;
      cmpBit <= 1'b0;
      dirBit <= 1'b0;
    end else begin
      if (stb.accept) dirBit <= dirReq;
      if (stb.capId)  idBit  <= slotRxBit;
      if (stb.capCmp) begin
        cmpBit <= slotRxBit;
        // a single responding polarity forces the branch
        if (idBit ^ slotRxBit) dirBit <= idBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultCode <= 3'b000;
      done       <= 1'b0;
    end else begin
      done <= stb.finishOk | stb.giveUp;
      if (stb.giveUp)        resultCode <= CODE_NONE;
      else if (stb.finishOk) resultCode <= {dirBit, cmpBit, idBit};
    end
  end

endmodule

// File: rtl/srch_triplet.sv
module srch_triplet
  import srch_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       dirReq,
  output logic       slotGo,
  output logic       slotWrite,
  output logic       slotWrBit,
  input  logic       slotAck,
  input  logic       slotRxBit,
  output logic       busy,
  output logic       done,
  output logic [2:0] resultCode
);

  dpStrobe_t stb;
  logic      bothOnes;

  srch_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .slotAck   (slotAck),
    .bothOnes  (bothOnes),
    .stb       (stb),
    .slotGo    (slotGo),
    .slotWrite (slotWrite),
    .busy      (busy)
  );

  srch_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dirReq     (dirReq),
    .slotRxBit  (slotRxBit),
    .stb        (stb),
    .bothOnes   (bothOnes),
    .slotWrBit  (slotWrBit),
    .resultCode (resultCode),
    .done       (done)
  );

endmodule

// File: rtl/srch_triplet_chk.sv
module srch_triplet_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       slotGo,
  input logic       busy,
  input logic       done,
  input logic [2:0] resultCode
);

  // R2: a slot request is a single-cycle pulse
  assert_go_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotGo |=> !slotGo);

  // R1: slots are only requested during a step
  assert_go_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    slotGo |-> busy);

  // R6: only legal codes are published
  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (resultCode == 3'd0 || resultCode == 3'd2 || resultCode == 3'd3 ||
              resultCode == 3'd4 || resultCode == 3'd5));

  // R5: with exactly one read bit set, the direction equals the ID bit
  assert_forced_dir_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && (resultCode[0] ^ resultCode[1])) |-> (resultCode[2] == resultCode[0]));

  // R9: done lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: the code only moves together with done
  assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultCode) |-> done);

  // R9: a step always ends with done
  assert_end_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: a step only begins from a start request
  assert_start_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

endmodule

bind srch_triplet srch_triplet_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .slotGo     (slotGo),
  .busy       (busy),
  .done       (done),
  .resultCode (resultCode)
);

// File: tb/sim_srch_triplet.sv
`timescale 1ns/1ps
module sim_srch_triplet;

  localparam int TO = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic dirReq = 1'b0;
  logic slotAck = 1'b0;
  logic slotRxBit = 1'b0;
  logic slotGo, slotWrite, slotWrBit, busy, done;
  logic [2:0] resultCode;

  always #4 clk = ~clk;

  srch_triplet #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dirReq(dirReq),
    .slotGo(slotGo), .slotWrite(slotWrite), .slotWrBit(slotWrBit),
    .slotAck(slotAck), .slotRxBit(slotRxBit),
    .busy(busy), .done(done), .resultCode(resultCode)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // ---------------- slot master responder ----------------
  int  dly [3];      // 0 = never answer
  bit  rxv [2];
  int  sIdx = 0;
  int  sCnt = 0;
  bit  pendRx = 0;
  int  wrCount = 0;
  bit  wrBitSeen = 0;
  int  doneCount = 0;

  initial begin
    forever begin
      @(negedge clk);
      slotAck   = 1'b0;
      slotRxBit = ~pendRx;   // junk outside acknowledge cycles
      if (sCnt > 0) begin
        sCnt--;
        if (sCnt == 0) begin
          slotAck   = 1'b1;
          slotRxBit = pendRx;
        end
      end
      if (slotGo === 1'b1 && sIdx < 3) begin
        if (slotWrite) begin
          wrCount++;
          wrBitSeen = slotWrBit;
        end else begin
          pendRx = rxv[sIdx > 1 ? 1 : sIdx];
        end
        sCnt = dly[sIdx];
        sIdx++;
      end
    end
  end

  // ---------------- behavioural reference ----------------
  int mStage = 0;
  bit mIss = 0;
  int mCnt = 0;
  bit mId = 0, mCmp = 0, mDir = 0, mDone = 0;
  int mRes = 0;

  initial begin
    forever begin
      @(posedge clk);
      if (!rstN) begin
        mStage = 0; mIss = 0; mCnt = 0; mDone = 0; mRes = 0;
      end else begin
        mDone = 0;
        if (mStage == 0) begin
          if (startReq) begin mStage = 1; mIss = 0; mDir = dirReq; end
        end else if (!mIss) begin
          mIss = 1; mCnt = 0;
        end else if (slotAck) begin
          mIss = 0;
          if (mStage == 1) begin
            mId = slotRxBit; mStage = 2;
          end else if (mStage == 2) begin
            mCmp = slotRxBit;
            if (mId && mCmp) begin mRes = 3; mDone = 1; mStage = 0; end
            else begin
              if (mId != mCmp) mDir = mId;
              mStage = 3;
            end
          end else begin
            mRes = 4 * mDir + 2 * mCmp + mId; mDone = 1; mStage = 0;
          end
        end else if (mCnt == TO - 1) begin
          mRes = 3; mDone = 1; mStage = 0; mIss = 0;
        end else begin
          mCnt++;
        end
      end
    end
  end

  // every-cycle comparison, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        chk("R1 busy", busy, mStage != 0);
        chk("R2 slotGo", slotGo, (mStage != 0) && !mIss);
        chk("R2 slotWrite", slotWrite, mStage == 3);
        if (mStage == 3) chk("R4 slotWrBit", slotWrBit, mDir);
        chk("R9 done", done, mDone);
        chk("R6 resultCode", resultCode, mRes);
        if (done) doneCount++;
      end
    end
  end

  // ---------------- directed steps ----------------
  function automatic int expCode(bit d, bit i, bit c, bit tout);
    if (tout || (i && c)) return 3;
    if (!i && !c) return d ? 4 : 0;
    return i ? 5 : 2;
  endfunction

  task automatic startTrip(input bit d, input bit i, input bit c,
                           input int d0, input int d1, input int d2);
    dly[0] = d0; dly[1] = d1; dly[2] = d2;
    rxv[0] = i; rxv[1] = c;
    sIdx = 0; sCnt = 0; wrCount = 0; doneCount = 0;
    startReq = 1'b1; dirReq = d;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (done !== 1'b1 && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic endCheck(input string tag, input int code, input int writes,
                          input bit wbit);
    chk({tag, " code"}, resultCode, code);
    chk({tag, " writes"}, wrCount, writes);
    if (writes > 0) chk({tag, " wrbit"}, wrBitSeen, wbit);
  endtask

  task automatic trip(input string tag, input bit d, input bit i, input bit c,
                      input int d0, input int d1, input int d2, input bit tout);
    int e = expCode(d, i, c, tout);
    int w = (tout || (i && c)) ? (tout && dly[2] == 0 && !(i && c) ? 1 : 0) : 1;
    startTrip(d, i, c, d0, d1, d2);
    waitDone();
    w = (e == 3) ? ((tout && d2 == 0 && d0 != 0 && d1 != 0) ? 1 : 0) : 1;
    endCheck(tag, e, w, (i != c) ? i : d);
    repeat (3) @(negedge clk);
    chk({tag, " single done R9"}, doneCount, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset slotGo", slotGo, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset code", resultCode, 0);

    // R1: first slot is an ID read in the cycle after the start edge
    dly[0] = 2; dly[1] = 1; dly[2] = 1; rxv[0] = 1; rxv[1] = 0;
    sIdx = 0; sCnt = 0; wrCount = 0; doneCount = 0;
    startReq = 1'b1; dirReq = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    chk("R1 go after start", slotGo, 1);
    chk("R1 first slot read", slotWrite, 0);
    waitDone();
    endCheck("R5 id1", 5, 1, 1);
    repeat (3) @(negedge clk);

    trip("R5 id0", 1'b1, 1'b0, 1'b1, 3, 1, 2, 1'b0);
    trip("R4 dir1", 1'b1, 1'b0, 1'b0, 1, 1, 1, 1'b0);
    trip("R4 dir0", 1'b0, 1'b0, 1'b0, 2, 4, 1, 1'b0);
    trip("R3 none", 1'b1, 1'b1, 1'b1, 1, 2, 1, 1'b0);
    trip("R7 to id", 1'b1, 1'b0, 1'b1, 0, 1, 1, 1'b1);
    trip("R7 to wr", 1'b0, 1'b1, 1'b0, 1, 1, 0, 1'b1);
    trip("R7 edge ok", 1'b1, 1'b0, 1'b0, TO, TO, TO, 1'b0);
    trip("R7 late", 1'b1, 1'b0, 1'b0, 1, TO + 1, 1, 1'b1);

    // R8: start and flipped direction while busy are ignored
    startTrip(1'b0, 1'b0, 1'b0, 3, 3, 3);
    startReq = 1'b1; dirReq = 1'b1;
    repeat (4) @(negedge clk);
    startReq = 1'b0;
    waitDone();
    endCheck("R8 ignored", 0, 1, 0);
    repeat (12) @(negedge clk);
    chk("R8 no extra step busy", busy, 0);
    chk("R8 single done", doneCount, 1);

    // R9: start during the done cycle is taken
    startTrip(1'b1, 1'b1, 1'b1, 1, 1, 1);
    waitDone();
    chk("R9 done busy low", busy, 0);
    startTrip(1'b0, 1'b0, 1'b1, 1, 1, 1);
    chk("R9 restart go", slotGo, 1);
    waitDone();
    endCheck("R9 back2back", 2, 1, 0);
    repeat (3) @(negedge clk);

    wrapUp();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    wrapUp();
  end

endmodule